// File: doc/BRIEF.md
# Byte-Register SPI Command Engine

This block is a small SPI master that a host drives through eight byte-wide registers. The host fills an opcode register, three address registers and one payload register. It then writes a control byte that sets the outgoing byte count, the number of response bytes to collect and the clock speed. The engine runs the whole exchange in SPI mode 0 under a single chip-select assertion. Response bytes land in readable registers, and the busy flag in the control register shows when the exchange has finished.

Only outgoing lengths of 1, 2, 4 or 5 bytes can be encoded, and at most 3 response bytes can be collected. The three address registers sit in the register space in the reverse of the order in which they go out on the wire. Both SCK rates come from the system clock through integer half-period dividers set by parameters.

Top module: `bytereg_spi_cmd`

## Requirements
- R1: After reset, all eight offsets read 0x00, `spi_cs_n` is high and `spi_sck` is low.
- R2: A write to offset 0 with bits [7:5] equal to 3'b010 while idle starts a transfer. A write to offset 0 with any other value of bits [7:5] starts nothing and only stores bits [6:0].
- R3: Reading offset 0 returns the busy flag in bit 7 and the last stored control bits [6:0] below it.
- R4: Control bit 4 selects the SCK half period: HALF_FAST system cycles when it is 1 and HALF_SLOW when it is 0. The first SCK rising edge comes one half period after `spi_cs_n` falls.
- R5: Control bits [1:0] set the outgoing sequence. 0 sends opcode (offset 1). 1 sends opcode, payload (offset 7). 2 sends opcode, offset 4, offset 3, offset 2. 3 sends opcode, offset 4, offset 3, offset 2, payload. Each byte goes out MSB first.
- R6: The bus runs in mode 0. SCK idles low and is high only while chip select is low. MOSI changes only while SCK is low. One SCK rising edge occurs per transferred bit. MOSI is 0 during the response phase.
- R7: Control bits [3:2] give the response byte count, 0 to 3. The bits sampled on the rising edges after the outgoing bytes are assembled MSB first into offsets 5, 6 and 7 in order of arrival. A response register that is not filled reads 0x00 after the transfer.
- R8: Chip select stays low for exactly 2 x half-period x 8 x (outgoing + response bytes) system cycles. It rises together with the last SCK falling edge, and busy clears on the next cycle.
- R9: While busy, writes to any offset are ignored. A second start does not produce a second transfer.
- R10: Offsets 1 to 4 read back the last written opcode and address bytes. Offset 7 reads the third response byte, not the payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| spi_sck | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The bench builds the block with HALF_FAST = 1 and HALF_SLOW = 3. This covers the minimum one-cycle divider as well as a multi-cycle count, and keeps every transfer short. At that size it sweeps all 32 combinations of length code, response count and speed bit. A bench-side device model returns a computed byte stream, so the wire order, the response placement, the zeroed unused slots and the exact chip-select and busy timing are checked for every combination. Separate runs cover rejected control values and writes that arrive mid-transfer.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;

  localparam int BYTE_W    = 8;
  localparam int REG_AW    = 3;
  localparam int MAX_TX    = 5;
  localparam int MAX_RX    = 3;
  localparam int SLOT_W    = $clog2(MAX_RX);
  localparam int BIDX_W    = $clog2(8 * (MAX_TX + MAX_RX)) + 1;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SHIFT = 2'd1,
    SEQ_CLOSE = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic [BYTE_W-1:0] op;
    logic [BYTE_W-1:0] adr_lo;   // offset 2, last address byte on the wire
    logic [BYTE_W-1:0] adr_mid;  // offset 3
    logic [BYTE_W-1:0] adr_hi;   // offset 4, first address byte on the wire
    logic [BYTE_W-1:0] payload;  // offset 7 (write side)
  } cmd_bytes_t;

  // Outgoing byte count for the 2-bit length code.
  function automatic logic [2:0] tx_bytes(input logic [1:0] enc);
    case (enc)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

  // Bits on the wire for the whole exchange.
  function automatic logic [BIDX_W-1:0] total_bits(input logic [1:0] enc,
                                                   input logic [1:0] rxc);
    logic [BIDX_W-1:0] nbytes;
    nbytes = BIDX_W'(tx_bytes(enc)) + BIDX_W'(rxc);
    return nbytes << 3;
  endfunction

  // Byte sent at wire position pos for length code enc.
  function automatic logic [BYTE_W-1:0] wire_byte(input logic [2:0]  pos,
                                                  input logic [1:0]  enc,
                                                  input cmd_bytes_t  c);
    case (pos)
      3'd0:    return c.op;
      3'd1:    return (enc == 2'd1) ? c.payload : c.adr_hi;
      3'd2:    return c.adr_mid;
      3'd3:    return c.adr_lo;
      3'd4:    return c.payload;
      default: return '0;
    endcase
  endfunction

  function automatic logic is_start_code(input logic [BYTE_W-1:0] w);
    return w[7:5] == 3'b010;
  endfunction

endpackage

// File: rtl/spicmd_tick.sv
module spicmd_tick #(
  parameter int HALF_FAST = 2,
  parameter int HALF_SLOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int MAXH = (HALF_FAST > HALF_SLOW) ? HALF_FAST : HALF_SLOW;
  localparam int CW   = (MAXH < 2) ? 1 : $clog2(MAXH);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;

  assign limit = fast ? CW'(HALF_FAST - 1) : CW'(HALF_SLOW - 1);
  assign tick  = run && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || tick)   cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spicmd_seq.sv
module spicmd_seq
  import spicmd_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [1:0]                    enc,
  input  logic [1:0]                    rx_cnt,
  input  cmd_bytes_t                    cmd,
  input  logic                          tick,
  input  logic                          miso,
  output logic                          busy,
  output logic                          shifting,
  output logic                          cs_n,
  output logic                          sck,
  output logic                          mosi,
  output logic [MAX_RX-1:0][BYTE_W-1:0] rx_bytes
);
  seq_state_t                    state_q;
  logic                          cs_n_q, sck_q, mosi_q;
  logic [BIDX_W-1:0]             bidx_q;
  logic [MAX_RX-1:0][BYTE_W-1:0] rx_q;

  logic [BIDX_W-1:0] tx_bits, n_bits;
  logic              in_rx, last_bit;
  logic [SLOT_W-1:0] slot;

  function automatic logic bit_at(input logic [BIDX_W-1:0] idx,
                                  input logic [BIDX_W-1:0] txb,
                                  input logic [1:0]        e,
                                  input cmd_bytes_t        c);
    logic [BYTE_W-1:0] b;
    if (idx >= txb) return 1'b0;
    b = wire_byte(3'(idx >> 3), e, c);
    return b[~idx[2:0]];
  endfunction

  assign tx_bits  = BIDX_W'(tx_bytes(enc)) << 3;
  assign n_bits   = total_bits(enc, rx_cnt);
  assign in_rx    = bidx_q >= tx_bits;
  assign last_bit = bidx_q == (n_bits - 1'b1);
  assign slot     = SLOT_W'((bidx_q - tx_bits) >> 3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cs_n_q  <= 1'b1;
      sck_q   <= 1'b0;
      mosi_q  <= 1'b0;
      bidx_q  <= '0;
      rx_q    <= '0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q <= SEQ_SHIFT;
            cs_n_q  <= 1'b0;
            sck_q   <= 1'b0;
            bidx_q  <= '0;
            mosi_q  <= cmd.op[BYTE_W-1];
            rx_q    <= '0;
          end
        end
        SEQ_SHIFT: begin
          if (tick) begin
            if (!sck_q) begin
              sck_q <= 1'b1;
              if (in_rx) rx_q[slot][~bidx_q[2:0]] <= miso;
            end else begin
              sck_q <= 1'b0;
              if (last_bit) begin
                cs_n_q  <= 1'b1;
                mosi_q  <= 1'b0;
                state_q <= SEQ_CLOSE;
              end else begin
                bidx_q <= bidx_q + 1'b1;
                mosi_q <= bit_at(bidx_q + 1'b1, tx_bits, enc, cmd);
              end
            end
          end
        end
        SEQ_CLOSE: state_q <= SEQ_IDLE;
        default:   state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy     = state_q != SEQ_IDLE;
  assign shifting = state_q == SEQ_SHIFT;
  assign cs_n     = cs_n_q;
  assign sck      = sck_q;
  assign mosi     = mosi_q;
  assign rx_bytes = rx_q;
endmodule

// File: rtl/spicmd_regfile.sv
module spicmd_regfile
  import spicmd_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [REG_AW-1:0]             addr,
  input  logic [BYTE_W-1:0]             wdata,
  input  logic                          busy,
  input  logic [MAX_RX-1:0][BYTE_W-1:0] rx_bytes,
  output logic [BYTE_W-1:0]             rdata,
  output logic                          start,
  output logic                          fast,
  output logic [1:0]                    rx_cnt,
  output logic [1:0]                    enc,
  output cmd_bytes_t                    cmd
);
  logic [BYTE_W-2:0] ctl_q;
  cmd_bytes_t        cmd_q;
  logic              wr_ok;

  assign wr_ok = we && !busy;
  assign start = wr_ok && (addr == 3'd0) && is_start_code(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cmd_q <= '0;
    end else if (wr_ok) begin
      case (addr)
        3'd0: ctl_q         <= wdata[BYTE_W-2:0];
        3'd1: cmd_q.op      <= wdata;
        3'd2: cmd_q.adr_lo  <= wdata;
        3'd3: cmd_q.adr_mid <= wdata;
        3'd4: cmd_q.adr_hi  <= wdata;
        3'd7: cmd_q.payload <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      3'd0:    rdata = {busy, ctl_q};
      3'd1:    rdata = cmd_q.op;
      3'd2:    rdata = cmd_q.adr_lo;
      3'd3:    rdata = cmd_q.adr_mid;
      3'd4:    rdata = cmd_q.adr_hi;
      3'd5:    rdata = rx_bytes[0];
      3'd6:    rdata = rx_bytes[1];
      default: rdata = rx_bytes[2];
    endcase
  end

  assign fast   = ctl_q[4];
  assign rx_cnt = ctl_q[3:2];
  assign enc    = ctl_q[1:0];
  assign cmd    = cmd_q;
endmodule

// File: rtl/bytereg_spi_cmd.sv
module bytereg_spi_cmd
  import spicmd_pkg::*;
#(
  parameter int HALF_FAST = 2,
  parameter int HALF_SLOW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic                          busy, shifting, tick, start_evt;
  logic                          ctl_fast;
  logic [1:0]                    ctl_rx, ctl_enc;
  cmd_bytes_t                    cmd;
  logic [MAX_RX-1:0][BYTE_W-1:0] rx_bytes;

  spicmd_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .busy     (busy),
    .rx_bytes (rx_bytes),
    .rdata    (reg_rdata),
    .start    (start_evt),
    .fast     (ctl_fast),
    .rx_cnt   (ctl_rx),
    .enc      (ctl_enc),
    .cmd      (cmd)
  );

  spicmd_tick #(.HALF_FAST(HALF_FAST), .HALF_SLOW(HALF_SLOW)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (shifting),
    .fast  (ctl_fast),
    .tick  (tick)
  );

  spicmd_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_evt),
    .enc      (ctl_enc),
    .rx_cnt   (ctl_rx),
    .cmd      (cmd),
    .tick     (tick),
    .miso     (spi_miso),
    .busy     (busy),
    .shifting (shifting),
    .cs_n     (spi_cs_n),
    .sck      (spi_sck),
    .mosi     (spi_mosi),
    .rx_bytes (rx_bytes)
  );
endmodule

// File: rtl/spicmd_checker.sv
module spicmd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       start,
  input logic       fast,
  input logic [1:0] rx_cnt,
  input logic [1:0] enc,
  input logic       sck,
  input logic       cs_n,
  input logic       mosi
);
  assert_cs_within_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  assert_busy_clears_after_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> !busy);

  assert_sck_only_selected_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n);

  assert_mosi_steady_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !cs_n && !sck));

  assert_ctl_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(fast) && $stable(rx_cnt) && $stable(enc)));
endmodule

bind bytereg_spi_cmd spicmd_checker u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy),
  .start  (start_evt),
  .fast   (ctl_fast),
  .rx_cnt (ctl_rx),
  .enc    (ctl_enc),
  .sck    (spi_sck),
  .cs_n   (spi_cs_n),
  .mosi   (spi_mosi)
);

// File: tb/sim_bytereg_spi_cmd.sv
module sim_bytereg_spi_cmd;
  localparam int HF  = 1;
  localparam int HS  = 3;
  localparam int PER = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       miso = 1'b0;
  wire  [7:0] rdata;
  wire        sck, csn, mosi;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  bytereg_spi_cmd #(.HALF_FAST(HF), .HALF_SLOW(HS)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .spi_sck(sck), .spi_cs_n(csn), .spi_mosi(mosi), .spi_miso(miso)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // device model and wire monitor
  logic [7:0]  seed = 8'h00;
  int          rises = 0;
  int          csfalls = 0;
  int          sidx = 0;
  logic [63:0] mbits = '0;
  time         t_csfall = 0, t_csrise = 0, t_rise1 = 0;

  function automatic logic [7:0] sbyte(input int j, input logic [7:0] s);
    return 8'h5A ^ 8'(j * 29) ^ s;
  endfunction

  always @(negedge csn) begin
    logic [7:0] b;
    csfalls++;
    t_csfall = $time;
    rises = 0;
    mbits = '0;
    sidx = 0;
    b = sbyte(0, seed);
    miso = b[7];
  end

  always @(posedge csn) t_csrise = $time;

  always @(posedge sck) begin
    if (rises == 0) t_rise1 = $time;
    if (rises < 64) mbits[63 - rises] = mosi;
    rises++;
  end

  always @(negedge sck) begin
    logic [7:0] b;
    sidx++;
    b = sbyte(sidx / 8, seed);
    miso = b[7 - (sidx % 8)];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic wait_idle(output time t);
    t = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      addr = 3'd0;
      #1;
      if (!rdata[7]) begin
        t = $time;
        break;
      end
    end
  endtask

  task automatic xfer(input int enc, input int rxc, input int fast, input int t);
    logic [7:0]  op, a2, a3, a4, dat, ctl, v;
    logic [63:0] exp;
    logic [7:0]  seqb [5];
    int          txl, nbits, h;
    time         tb;
    seed = 8'(t * 13 + 7);
    op = 8'(8'h90 + t); a2 = 8'(t * 3 + 1); a3 = 8'(t * 5 + 2);
    a4 = 8'(t * 7 + 3); dat = 8'(~t);
    wr(3'd1, op); wr(3'd2, a2); wr(3'd3, a3); wr(3'd4, a4); wr(3'd7, dat);
    ctl = {3'b010, 1'(fast), 2'(rxc), 2'(enc)};
    wr(3'd0, ctl);
    wait_idle(tb);
    txl = (enc == 0) ? 1 : (enc == 1) ? 2 : (enc == 2) ? 4 : 5;
    h = fast ? HF : HS;
    nbits = 8 * (txl + rxc);
    seqb[0] = op;
    if (enc == 1) seqb[1] = dat;
    else begin seqb[1] = a4; seqb[2] = a3; seqb[3] = a2; seqb[4] = dat; end
    exp = '0;
    for (int k = 0; k < txl; k++) exp[63 - 8 * k -: 8] = seqb[k];
    check($sformatf("R5 wire bytes enc=%0d rx=%0d", enc, rxc), mbits, exp);
    check("R6 rising edge count", 64'(rises), 64'(nbits));
    check($sformatf("R4 first rise delay fast=%0d", fast), 64'(t_rise1 - t_csfall), 64'(h * PER));
    check("R8 chip select low time", 64'(t_csrise - t_csfall), 64'(2 * h * nbits * PER));
    check("R8 busy clear one cycle after cs", 64'(tb - t_csrise), 64'(PER + PER / 2 + 1));
    for (int k = 0; k < 3; k++) begin
      rd(3'(5 + k), v);
      check($sformatf("R7 response slot %0d rx=%0d", k, rxc), 64'(v),
            64'((k < rxc) ? sbyte(txl + k, seed) : 8'h00));
    end
    rd(3'd0, v);
    check("R3 control readback", 64'(v), 64'({1'b0, ctl[6:0]}));
    begin
      logic [7:0] r1, r2, r3, r4;
      rd(3'd1, r1); rd(3'd2, r2); rd(3'd3, r3); rd(3'd4, r4);
      check("R10 opcode/address readback", 64'({r1, r2, r3, r4}), 64'({op, a2, a3, a4}));
    end
  endtask

  initial begin
    logic [7:0] v;
    int         cf0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check($sformatf("R1 reset value offset %0d", a), 64'(v), 64'h0);
    end
    check("R1 reset pins", 64'({csn, sck}), 64'(2'b10));

    // exhaustive sweep
    for (int e = 0; e < 4; e++)
      for (int r = 0; r < 4; r++)
        for (int f = 0; f < 2; f++)
          xfer(e, r, f, e * 8 + r * 2 + f);

    // R2 non-start control values
    cf0 = csfalls;
    wr(3'd0, 8'h3D);
    repeat (20) @(negedge clk);
    check("R2 no transfer for upper 3'b001", 64'(csfalls - cf0), 64'h0);
    rd(3'd0, v);
    check("R3 stored bits without start", 64'(v), 64'h3D);
    wr(3'd0, 8'hC5);
    repeat (20) @(negedge clk);
    check("R2 no transfer for upper 3'b110", 64'({csfalls - cf0, 1'(csn)}), 64'({32'h0, 1'b1}));
    rd(3'd0, v);
    check("R3 bit7 not stored", 64'(v), 64'h45);

    // R9 writes while busy are dropped
    seed = 8'h11;
    wr(3'd1, 8'h9F);
    cf0 = csfalls;
    wr(3'd0, 8'h50);
    wr(3'd0, 8'h5F);
    wr(3'd1, 8'hEE);
    begin
      time tb;
      wait_idle(tb);
    end
    repeat (30) @(negedge clk);
    check("R9 single transfer", 64'(csfalls - cf0), 64'h1);
    check("R9 bit count unchanged", 64'(rises), 64'd8);
    check("R9 wire byte", 64'(mbits[63:56]), 64'h9F);
    rd(3'd0, v);
    check("R9 control kept", 64'(v), 64'h50);
    rd(3'd1, v);
    check("R9 opcode kept", 64'(v), 64'h9F);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule